// File: doc/BRIEF.md
# Register-Addressed SPI Slave Engine

This block is a serial peripheral slave that runs in SPI mode 0 with an active-low chip select. A host talks to it in commands. The first byte of each command names a register. The bytes after it are that register's payload. The block looks the address up in an internal length table, collects exactly that many payload bytes (MSB first), and then raises a one-cycle write strobe. The strobe carries the address and the payload, packed from the top of a 56-bit bus down. Several commands may follow one another inside a single chip-select window.

The slave output line is driven from a 7-byte result buffer. Command-execution logic outside the block loads this buffer. A dedicated read address clocks the buffer out over seven dummy bytes, so the host collects the result of an earlier command. If chip select rises after the address byte but before the payload is complete, the engine locks up. It then ignores all further bus activity and raises a hung flag until a hard reset.

The SPI pins are sampled with the system clock through two-stage synchronisers, so the serial clock must run well below the system clock.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, wrStb, wrAddr, wrData, miso and hung are all zero.
- R2: The first byte after chip select falls is taken MSB first from mosi as the register address, and it appears on wrAddr with the strobe.
- R3: The payload length in bytes is 7 for the read address 0x26, is addr-0x0F for addresses 0x10 to 0x16 (1 to 7 bytes), and is 1 for every other address.
- R4: Once the last payload byte has been received, wrStb is high for exactly one clock. wrData holds payload byte 0 in bits [55:48], byte 1 in [47:40] and so on, and every bit below the payload is zero.
- R5: Commands placed back to back within one chip-select-low window each produce their own strobe, with their own address and data.
- R6: If chip select rises before 8 address bits have arrived, the partial byte is discarded. The engine does not hang, and the next command is received normally.
- R7: If chip select rises after the address byte but before the full payload, hung goes high. It stays high through any later bus activity, with no strobes and miso held at 0, until rstN is asserted.
- R8: A command to address 0x26 produces no write strobe. During its seven payload bytes, miso shifts out the result buffer MSB first, starting with bits [55:48].
- R9: miso is 0 during every address byte, during the payload bytes of any address other than 0x26, and while chip select is high.
- R10: A high rspValid loads rspData into the result buffer, and the next read command returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low hard reset, the only way out of the hung state |
| sclk | input | 1 | Serial clock, idle low |
| csN | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| rspValid | input | 1 | Loads the result buffer |
| rspData | input | 56 | Result data for the buffer |
| wrStb | output | 1 | One-cycle register write strobe |
| wrAddr | output | 8 | Address of the completed command |
| wrData | output | 56 | Payload, first byte in the top bits |
| hung | output | 1 | Engine locked after a short frame |

## Verification
The bench builds the block with its default parameters: a 7-byte payload limit, read address 0x26 and a length-table base of 0x10. With these values, a sweep over all 256 addresses covers every entry of the length table, including every payload size from 1 to 7 bytes. For each address the bench checks the strobe count, the address, the packed data and the returned miso bytes against values computed from the address. Directed frames then cover back-to-back commands, a truncated address byte, two buffer reloads followed by reads, and the lockup that only a reset clears.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HUNG = 2'd3
  } engState_e;

  // control -> datapath
  typedef struct packed {
    logic             clearBits;
    logic             latchAddr;
    logic             clrData;
    logic             latchData;
    logic             loadTx;
    logic             txFromBuf;
    logic             shiftTx;
    logic             fireWr;
    logic [IDX_W-1:0] byteIdx;
    logic [IDX_W-1:0] txIdx;
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic       csActive;
    logic       sclkRise;
    logic       sclkFall;
    logic       byteDone;
    logic       bitZero;
    logic [7:0] rxByte;
  } spiEvents_t;

  // payload length table
  function automatic int frameLen(input logic [7:0] addr,
                                  input logic [7:0] rdAddr,
                                  input logic [7:0] baseAddr,
                                  input int         maxBytes);
    int off;
    off = int'(addr) - int'(baseAddr);
    case (1'b1)
      (addr == rdAddr):              return maxBytes;
      (off >= 0 && off < maxBytes):  return off + 1;
      default:                       return 1;
    endcase
  endfunction

endpackage

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int DATA_BYTES = 7,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  input  ctlStrobes_t       ctl,
  output spiEvents_t        ev,
  output logic              miso,
  output logic              wrStb,
  output logic [7:0]        wrAddr,
  output logic [DATA_W-1:0] wrData
);

  logic [2:0]        sclkQ;
  logic [1:0]        csQ;
  logic [1:0]        mosiQ;
  logic [2:0]        bitCnt;
  logic [7:0]        rxShift;
  logic [7:0]        txShift;
  logic [7:0]        addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] outBuf;
  logic [DATA_W-1:0] bufShifted;
  logic [DATA_W-1:0] placedByte;
  logic              csAct;
  logic              sRise;
  logic              sFall;

  // pin synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= '0;
      csQ   <= 2'b11;
      mosiQ <= '0;
    end else begin
      sclkQ <= {sclkQ[1:0], sclk};
      csQ   <= {csQ[0], csN};
      mosiQ <= {mosiQ[0], mosi};
    end
  end

  assign sRise = sclkQ[1] & ~sclkQ[2];
  assign sFall = ~sclkQ[1] & sclkQ[2];
  assign csAct = ~csQ[1];

  always_comb begin
    ev.csActive = csAct;
    ev.sclkRise = csAct & sRise;
    ev.sclkFall = csAct & sFall;
    ev.byteDone = csAct & sRise & (bitCnt == 3'd7);
    ev.bitZero  = (bitCnt == 3'd0);
    ev.rxByte   = {rxShift[6:0], mosiQ[1]};
  end

  // receive side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      if (ctl.clearBits)
        bitCnt <= '0;
      else if (ev.sclkRise)
        bitCnt <= bitCnt + 3'd1;
      if (ev.sclkRise)
        rxShift <= ev.rxByte;
    end
  end

  assign placedByte = {ev.rxByte, {(DATA_W-8){1'b0}}} >> (8 * ctl.byteIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (ctl.latchAddr)
        addrReg <= ev.rxByte;
      if (ctl.clrData)
        dataReg <= '0;
      else if (ctl.latchData)
        dataReg <= dataReg | placedByte;
    end
  end

  // result buffer and transmit side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      outBuf <= '0;
    else if (rspValid)
      outBuf <= rspData;
  end

  assign bufShifted = outBuf << (8 * ctl.txIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      txShift <= '0;
    else if (ctl.loadTx)
      txShift <= ctl.txFromBuf ? bufShifted[DATA_W-1 -: 8] : 8'h00;
    else if (ctl.shiftTx)
      txShift <= {txShift[6:0], 1'b0};
  end

  assign miso = txShift[7];

  // write strobe outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStb  <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrStb <= ctl.fireWr;
      if (ctl.fireWr) begin
        wrAddr <= addrReg;
        wrData <= dataReg;
      end
    end
  end

endmodule

// File: rtl/spi_reg_control.sv
module spi_reg_control
  import spi_reg_pkg::*;
#(
  parameter int         DATA_BYTES = 7,
  parameter logic [7:0] RD_ADDR    = 8'h26,
  parameter logic [7:0] LEN_BASE   = 8'h10
) (
  input  logic        clk,
  input  logic        rstN,
  input  spiEvents_t  ev,
  output ctlStrobes_t ctl,
  output logic        hung
);

  engState_e        state, stateNx;
  logic [IDX_W-1:0] byteIdx, byteIdxNx;
  logic [IDX_W-1:0] lastIdx, lastIdxNx;
  logic             isRead, isReadNx;
  logic             wrPend, wrPendNx;
  int               lenNow;

  assign lenNow = frameLen(ev.rxByte, RD_ADDR, LEN_BASE, DATA_BYTES);

  always_comb begin
    stateNx   = state;
    byteIdxNx = byteIdx;
    lastIdxNx = lastIdx;
    isReadNx  = isRead;
    wrPendNx  = 1'b0;
    ctl         = '0;
    ctl.byteIdx = byteIdx;
    ctl.fireWr  = wrPend;
    ctl.shiftTx = ev.sclkFall & ~ev.bitZero &
                  ((state == ST_ADDR) || (state == ST_DATA));
    unique case (state)
      ST_IDLE: begin
        ctl.clearBits = 1'b1;
        ctl.loadTx    = 1'b1;
        if (ev.csActive)
          stateNx = ST_ADDR;
      end
      ST_ADDR: begin
        if (!ev.csActive) begin
          ctl.clearBits = 1'b1;
          ctl.loadTx    = 1'b1;
          stateNx       = ST_IDLE;
        end else if (ev.byteDone) begin
          ctl.latchAddr = 1'b1;
          ctl.clrData   = 1'b1;
          isReadNx      = (ev.rxByte == RD_ADDR);
          lastIdxNx     = IDX_W'(lenNow - 1);
          byteIdxNx     = '0;
          ctl.loadTx    = 1'b1;
          ctl.txFromBuf = isReadNx;
          ctl.txIdx     = '0;
          stateNx       = ST_DATA;
        end
      end
      ST_DATA: begin
        if (!ev.csActive) begin
          ctl.clearBits = 1'b1;
          ctl.loadTx    = 1'b1;
          stateNx       = ST_HUNG;
        end else if (ev.byteDone) begin
          ctl.latchData = 1'b1;
          ctl.loadTx    = 1'b1;
          if (byteIdx == lastIdx) begin
            wrPendNx = ~isRead;
            stateNx  = ST_ADDR;
          end else begin
            byteIdxNx     = byteIdx + 1'b1;
            ctl.txFromBuf = isRead;
            ctl.txIdx     = byteIdx + 1'b1;
          end
        end
      end
      ST_HUNG: begin
        ctl.clearBits = 1'b1;
      end
      default: stateNx = ST_HUNG;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
      lastIdx <= '0;
      isRead  <= 1'b0;
      wrPend  <= 1'b0;
    end else begin
      state   <= stateNx;
      byteIdx <= byteIdxNx;
      lastIdx <= lastIdxNx;
      isRead  <= isReadNx;
      wrPend  <= wrPendNx;
    end
  end

  assign hung = (state == ST_HUNG);

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int         DATA_BYTES = 7,
  parameter logic [7:0] RD_ADDR    = 8'h26,
  parameter logic [7:0] LEN_BASE   = 8'h10,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  output logic              wrStb,
  output logic [7:0]        wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              hung
);

  ctlStrobes_t ctl;
  spiEvents_t  ev;

  spi_reg_datapath #(.DATA_BYTES(DATA_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .rspValid(rspValid), .rspData(rspData), .ctl(ctl), .ev(ev),
    .miso(miso), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData)
  );

  spi_reg_control #(
    .DATA_BYTES(DATA_BYTES), .RD_ADDR(RD_ADDR), .LEN_BASE(LEN_BASE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .ctl(ctl), .hung(hung)
  );

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
#(
  parameter int         DATA_BYTES = 7,
  parameter logic [7:0] RD_ADDR    = 8'h26,
  parameter logic [7:0] LEN_BASE   = 8'h10,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              miso,
  input logic              wrStb,
  input logic [7:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              hung
);

  logic [DATA_W-1:0] tailMask;
  int                expLen;

  assign expLen = frameLen(wrAddr, RD_ADDR, LEN_BASE, DATA_BYTES);

  always_comb begin
    tailMask = '0;
    for (int b = 0; b < DATA_BYTES; b++)
      if (b >= expLen)
        tailMask[DATA_W-1-8*b -: 8] = 8'hFF;
  end

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb); // R4
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> ((wrData & tailMask) == '0)); // R4
  AST_NO_READ_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (wrAddr != RD_ADDR)); // R8
  AST_HUNG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    hung |=> hung); // R7
  AST_HUNG_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    hung |-> (!wrStb && !miso)); // R7
  AST_MISO_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !miso); // R9

endmodule

bind spi_reg_slave spi_reg_slave_chk #(
  .DATA_BYTES(DATA_BYTES), .RD_ADDR(RD_ADDR), .LEN_BASE(LEN_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso), .wrStb(wrStb),
  .wrAddr(wrAddr), .wrData(wrData), .hung(hung)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
module sim_spi_reg_slave;

  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclk = 1'b0;
  logic        csN = 1'b1;
  logic        mosi = 1'b0;
  logic        rspValid = 1'b0;
  logic [55:0] rspData = '0;
  logic        miso;
  logic        wrStb;
  logic [7:0]  wrAddr;
  logic [55:0] wrData;
  logic        hung;

  int checks = 0;
  int errors = 0;
  int stbCnt = 0;
  logic [7:0]  capA = '0;
  logic [55:0] capD = '0;

  always #4 clk = ~clk;

  spi_reg_slave u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .rspValid(rspValid), .rspData(rspData), .wrStb(wrStb), .wrAddr(wrAddr),
    .wrData(wrData), .hung(hung)
  );

  always @(negedge clk) begin
    if (rstN && wrStb) begin
      stbCnt <= stbCnt + 1;
      capA   <= wrAddr;
      capD   <= wrData;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int expLen(input logic [7:0] a);
    if (a == 8'h26) return 7;
    if (a >= 8'h10 && a <= 8'h16) return int'(a) - 15;
    return 1;
  endfunction

  function automatic logic [7:0] patByte(input logic [7:0] a, input int k);
    return 8'((int'(a) * 7 + k * 29 + 3) & 255);
  endfunction

  task automatic xferBits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      clks(HALF);
      #1 rx[i] = miso;
      sclk = 1'b1;
      clks(HALF);
      #1 sclk = 1'b0;
    end
  endtask

  task automatic csLow();
    #1 csN = 1'b0;
    clks(HALF);
  endtask

  task automatic csHigh();
    clks(HALF);
    #1 csN = 1'b1;
    clks(14);
  endtask

  // one command inside an open chip-select window
  task automatic sendCmd(input logic [7:0] a, input int n, input logic [55:0] pl,
                         output logic [7:0] rxA, output logic [55:0] rxD);
    logic [7:0] r;
    xferBits(a, 8, rxA);
    rxD = '0;
    for (int k = 0; k < n; k++) begin
      xferBits(pl[55-8*k -: 8], 8, r);
      rxD[55-8*k -: 8] = r;
    end
  endtask

  task automatic doReset();
    #1 rstN = 1'b0;
    clks(5);
    #1 rstN = 1'b1;
    clks(3);
  endtask

  logic [55:0] pl, expD, rxD;
  logic [7:0]  rxA, dummy;
  int          s0, n;

  initial begin
    clks(5);
    #1;
    chk(wrStb == 0 && wrAddr == 0 && wrData == 0 && miso == 0 && hung == 0,
        "R1 reset state", {wrStb, wrAddr, hung, miso}, 0);
    #1 rstN = 1'b1;
    clks(3);
    #1;
    chk(wrStb == 0 && hung == 0 && miso == 0, "R1 after release",
        {wrStb, hung, miso}, 0);

    // R10: load result buffer
    @(negedge clk);
    rspData = 56'hA1B2C3D4E5F607; rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0; rspData = '0;

    // sweep every address: R2 R3 R4 R8 R9
    for (int a = 0; a < 256; a++) begin
      n  = expLen(8'(a));
      pl = '0;
      for (int k = 0; k < n; k++) pl[55-8*k -: 8] = patByte(8'(a), k);
      s0 = stbCnt;
      csLow();
      sendCmd(8'(a), n, pl, rxA, rxD);
      csHigh();
      chk(rxA == 0, "R9 miso during address", rxA, 0);
      if (a == 8'h26) begin
        chk(stbCnt == s0, "R8 no strobe for read", stbCnt - s0, 0);
        chk(rxD == 56'hA1B2C3D4E5F607, "R8 read data", rxD, 56'hA1B2C3D4E5F607);
      end else begin
        chk(stbCnt == s0 + 1, "R3 one strobe after full payload", stbCnt - s0, 1);
        chk(capA == 8'(a), "R2 address", capA, a);
        chk(capD == pl, "R4 packed data", capD, pl);
        chk(rxD == 0, "R9 miso zero on write", rxD, 0);
      end
      chk(hung == 0, "R3 no hang on exact length", hung, 0);
    end

    // R5: back-to-back commands in one window
    s0 = stbCnt;
    csLow();
    sendCmd(8'h10, 1, {8'h5A, 48'h0}, rxA, rxD);
    sendCmd(8'h11, 2, {16'hC33C, 40'h0}, rxA, rxD);
    clks(8);
    #1;
    chk(stbCnt == s0 + 2, "R5 two strobes", stbCnt - s0, 2);
    chk(capA == 8'h11 && capD == {16'hC33C, 40'h0}, "R5 second command",
        {capA, capD}, {8'h11, 16'hC33C, 40'h0});
    csHigh();

    // R6: truncated address byte
    csLow();
    xferBits(8'hFF, 3, dummy);
    csHigh();
    chk(hung == 0, "R6 no hang on partial address", hung, 0);
    s0 = stbCnt;
    csLow();
    sendCmd(8'h12, 3, {24'h123456, 32'h0}, rxA, rxD);
    csHigh();
    chk(stbCnt == s0 + 1 && capA == 8'h12, "R6 next command received",
        {stbCnt - s0, capA}, {32'd1, 8'h12});
    chk(capD == {24'h123456, 32'h0}, "R6 next command data", capD,
        {24'h123456, 32'h0});

    // R10: reload and read again
    @(negedge clk);
    rspData = 56'h0F1E2D3C4B5A69; rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
    csLow();
    sendCmd(8'h26, 7, '0, rxA, rxD);
    csHigh();
    chk(rxD == 56'h0F1E2D3C4B5A69, "R10 reloaded buffer", rxD, 56'h0F1E2D3C4B5A69);

    // R7: short frame lockup
    s0 = stbCnt;
    csLow();
    sendCmd(8'h12, 1, {8'hAA, 48'h0}, rxA, rxD);
    csHigh();
    chk(hung == 1, "R7 hung after short frame", hung, 1);
    csLow();
    sendCmd(8'h26, 7, '0, rxA, rxD);
    csHigh();
    chk(rxD == 0 && rxA == 0, "R7 miso silent while hung", rxD, 0);
    csLow();
    sendCmd(8'h10, 1, {8'h77, 48'h0}, rxA, rxD);
    csHigh();
    chk(stbCnt == s0, "R7 no strobe while hung", stbCnt - s0, 0);
    chk(hung == 1, "R7 still hung after traffic", hung, 1);
    doReset();
    chk(hung == 0, "R7 reset clears hang", hung, 0);
    csLow();
    sendCmd(8'h14, 5, {40'hDEADBEEF01, 16'h0}, rxA, rxD);
    csHigh();
    chk(stbCnt == s0 + 1 && capD == {40'hDEADBEEF01, 16'h0}, "R7 works after reset",
        capD, {40'hDEADBEEF01, 16'h0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clks(190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule